// File: doc/BRIEF.md
# Windowed Clock Frequency Checker

The block estimates the frequency of one on-chip clock by counting its rising edges while a fixed window of reference-clock cycles is open, then judges the count against a pair of programmed bounds. The reference clock also clocks the host write port, so every register and status bit lives in one domain. Only the edge counter runs on the measured clock. The window opening and closing cross into that domain through two-flop synchronizers. A toggle crosses back to report that the count has settled.

Software first writes the enable bit together with a clock index. It waits for the chosen source to settle, then sets the start bit while keeping enable and index unchanged. It polls the done flag and reads the count and the pass flag. Clearing start returns the engine to idle and zeroes the count, so polling the count field for zero confirms that the engine is ready. The measured frequency is f_ref / W * (count + 1), where W is the window length.

Top module: `clk_freq_checker`

## Requirements
- R1: After reset the control/status word and the limit word read zero. In the control/status word, bit 0 is enable, bit 1 is start, and bits [5:2] are the clock index. Each reads back as last written, from the cycle after the write.
- R2: A measurement holds the window open for WIN_LEN (default 512) reference cycles. The reported count equals the number of measured-clock rising edges in the window minus one, within two counts.
- R3: The count is 14 bits wide, appears in bits [29:16], and saturates at 16383 rather than wrapping. It does not change while done is set.
- R4: A measurement runs only while enable and start are both 1. With start set and enable clear, done stays 0 and the count stays 0.
- R5: The limit word holds the low bound in bits [15:0] and the high bound in bits [31:16]. Bit 7 (pass) is 1 exactly when done is set and low <= count <= high, both bounds inclusive. Pass follows the current limit word.
- R6: Bit 6 (done) rises once a window has closed and its count has been captured. Pass is never 1 without done. Writing start = 0 clears both flags.
- R7: A write with start = 0 zeroes the count field within two cycles.
- R8: While start is set, writes to the clock index are ignored. The index reads back unchanged, and the running measurement keeps counting the originally chosen clock.
- R9: Writing an all-zero control word returns the engine to idle: enable, start, done, pass and count all read zero.
- R10: The index selects which of NUM_CLKS inputs is counted. Clocks of different rates give counts in proportion to their rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference and register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| meas_clks_i | input | NUM_CLKS | Candidate clocks to measure |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 selects control/status, 1 selects limits |
| wr_data_i | input | 32 | Write data |
| csr_o | output | 32 | Control/status readback |
| limit_o | output | 32 | Limit word readback |

## Verification
A write lands on the next reference edge, so register fields are checked one cycle after the strobe. Done, pass and count clear one cycle later because the window controller is registered; the bench therefore waits two cycles after an idle write before it checks them. Done is due about WIN_LEN cycles after start, plus a few measured-clock cycles of synchronizer latency in each direction. The bench polls done at falling edges under a bound of a few thousand cycles, and checks counts with a tolerance of two to cover synchronizer phase. Pass reacts to a limit change one cycle after the write, so each limit value is checked one cycle after it is written.

// File: rtl/cfc_pkg.sv
`timescale 1ns/1ps
package cfc_pkg;
  localparam int CNT_W   = 14;
  localparam int SEL_FW  = 4;
  localparam int EN_B    = 0;
  localparam int START_B = 1;
  localparam int SEL_LSB = 2;
  localparam int DONE_B  = 6;
  localparam int PASS_B  = 7;
  localparam int CNT_LSB = 16;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_WIN, ST_WAIT, ST_DONE} win_st_e;
endpackage

// File: rtl/cfc_sync.sv
`timescale 1ns/1ps
module cfc_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cfc_tgt_cnt.sv
`timescale 1ns/1ps
module cfc_tgt_cnt import cfc_pkg::*; (
  input  logic             tgt_clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tgl_o
);
  logic gate_s, gate_d, tgl_q;
  logic [CNT_W-1:0] cnt_q;

  cfc_sync #(.W(1)) u_gate_sync (
    .clk_i (tgt_clk_i),
    .rst_ni(rst_ni),
    .d_i   (gate_i),
    .q_o   (gate_s)
  );

  always_ff @(posedge tgt_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_d <= 1'b0;
      cnt_q  <= '0;
      tgl_q  <= 1'b0;
    end else begin
      gate_d <= gate_s;
      // first edge of the window is edge zero
      if (gate_s && !gate_d)                 cnt_q <= '0;
      else if (gate_s && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      // count is frozen before the toggle leaves
      if (!gate_s && gate_d)                 tgl_q <= ~tgl_q;
    end
  end

  assign cnt_o = cnt_q;
  assign tgl_o = tgl_q;

  AST_CNT_SAT: assert property (@(posedge tgt_clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX) || (cnt_q == '0)); // R3
endmodule

// File: rtl/cfc_win_ctrl.sv
`timescale 1ns/1ps
module cfc_win_ctrl import cfc_pkg::*; #(
  parameter int WIN_LEN = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tgl_s_i,
  input  logic [CNT_W-1:0] tgt_cnt_i,
  output logic             gate_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int TMR_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WIN_LEN - 1);

  win_st_e          st_q;
  logic [TMR_W-1:0] tmr_q;
  logic             gate_q, tgl_d;
  logic [CNT_W-1:0] cnt_q;
  logic             tgl_edge;

  assign tgl_edge = tgl_s_i ^ tgl_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      gate_q <= 1'b0;
      tgl_d  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      tgl_d <= tgl_s_i;
      if (!run_i) begin
        st_q   <= ST_IDLE;
        gate_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            st_q   <= ST_WIN;
            tmr_q  <= '0;
            gate_q <= 1'b1;
          end
          ST_WIN: begin
            if (tmr_q == TMR_LAST) begin
              st_q   <= ST_WAIT;
              gate_q <= 1'b0;
            end else begin
              tmr_q <= tmr_q + 1'b1;
            end
          end
          ST_WAIT: begin
            if (tgl_edge) begin
              cnt_q <= tgt_cnt_i;
              st_q  <= ST_DONE;
            end
          end
          ST_DONE: ;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign gate_o = gate_q;
  assign done_o = (st_q == ST_DONE);
  assign cnt_o  = cnt_q;

  AST_WIN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(gate_q) && $past(run_i)) |-> ($past(tmr_q) == TMR_LAST)); // R2
  AST_IDLE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0) && !done_o); // R7
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> $stable(cnt_q)); // R3
endmodule

// File: rtl/clk_freq_checker.sv
`timescale 1ns/1ps
module clk_freq_checker import cfc_pkg::*; #(
  parameter int NUM_CLKS = 16,
  parameter int WIN_LEN  = 512
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CLKS-1:0] meas_clks_i,
  input  logic                wr_en_i,
  input  logic                wr_addr_i,
  input  logic [31:0]         wr_data_i,
  output logic [31:0]         csr_o,
  output logic [31:0]         limit_o
);
  localparam int MUX_N = 1 << SEL_FW;

  logic              en_q, start_q, run;
  logic [SEL_FW-1:0] sel_q;
  logic [31:0]       lim_q;
  logic [MUX_N-1:0]  clk_vec;
  logic              tgt_clk, gate, tgl_t, tgl_s, done, pass;
  logic [CNT_W-1:0]  tgt_cnt, cnt;
  logic [15:0]       cnt_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      start_q <= 1'b0;
      sel_q   <= '0;
      lim_q   <= '0;
    end else if (wr_en_i) begin
      if (!wr_addr_i) begin
        en_q    <= wr_data_i[EN_B];
        start_q <= wr_data_i[START_B];
        // index frozen while a measurement is requested
        if (!start_q) sel_q <= wr_data_i[SEL_LSB +: SEL_FW];
      end else begin
        lim_q <= wr_data_i;
      end
    end
  end

  assign run = en_q & start_q;

  if (NUM_CLKS < MUX_N) begin : g_pad
    assign clk_vec = {{(MUX_N-NUM_CLKS){1'b0}}, meas_clks_i};
  end else begin : g_full
    assign clk_vec = meas_clks_i[MUX_N-1:0];
  end

  assign tgt_clk = clk_vec[sel_q];

  cfc_tgt_cnt u_tgt_cnt (
    .tgt_clk_i(tgt_clk),
    .rst_ni   (rst_ni),
    .gate_i   (gate),
    .cnt_o    (tgt_cnt),
    .tgl_o    (tgl_t)
  );

  cfc_sync #(.W(1)) u_tgl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tgl_t),
    .q_o   (tgl_s)
  );

  cfc_win_ctrl #(.WIN_LEN(WIN_LEN)) u_win_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .tgl_s_i  (tgl_s),
    .tgt_cnt_i(tgt_cnt),
    .gate_o   (gate),
    .done_o   (done),
    .cnt_o    (cnt)
  );

  assign cnt_ext = {{(16-CNT_W){1'b0}}, cnt};
  assign pass    = done && (cnt_ext >= lim_q[15:0]) && (cnt_ext <= lim_q[31:16]);

  always_comb begin
    csr_o                         = '0;
    csr_o[EN_B]                   = en_q;
    csr_o[START_B]                = start_q;
    csr_o[SEL_LSB +: SEL_FW]      = sel_q;
    csr_o[DONE_B]                 = done;
    csr_o[PASS_B]                 = pass;
    csr_o[CNT_LSB +: CNT_W]       = cnt;
  end

  assign limit_o = lim_q;

  AST_PASS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_o[PASS_B] |-> csr_o[DONE_B]); // R6
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && $past(start_q)) |-> $stable(sel_q)); // R8
  AST_NO_EN_NO_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !gate); // R4
  AST_DISABLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !$past(en_q)) |-> !done && (cnt == '0)); // R9
endmodule

// File: tb/clk_freq_checker_tb_top.sv
`timescale 1ns/1ps
module clk_freq_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        c0 = 1'b0, c1 = 1'b0, c2 = 1'b0, c3 = 1'b0;
  logic        sat_en = 1'b0;
  logic        wr_en = 1'b0, wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] csr, lim;
  logic [15:0] meas;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;          // 200 MHz reference
  always #5   c0  = ~c0;           // 10 ns
  always #4   c1  = ~c1;           // 8 ns
  always #20  c3  = ~c3;           // 40 ns
  initial forever begin            // 120 ps, only when needed
    wait (sat_en);
    #0.06 c2 = ~c2;
  end

  assign meas = {12'b0, c3, c2, c1, c0};

  clk_freq_checker dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .meas_clks_i(meas),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .csr_o      (csr),
    .limit_o    (lim)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input int act, input int exp);
    chk(req, (act >= exp - 2) && (act <= exp + 2), act, exp);
  endtask

  task automatic wr(input bit a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(input bit en, input bit st, input int sel);
    return {26'b0, 4'(sel), st, en};
  endfunction

  function automatic int cnt_of(input logic [31:0] v);
    return int'(v[29:16]);
  endfunction

  task automatic wait_done(input string req);
    bit seen = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (csr[6]) begin seen = 1'b1; break; end
    end
    chk(req, seen, 0, 1);
  endtask

  task automatic measure(input int sel, input string req);
    wr(1'b0, ctl(1, 0, sel));
    idle(20);
    wr(1'b0, ctl(1, 1, sel));
    wait_done(req);
  endtask

  task automatic t_reset;
    chk("R1 csr reset", csr == 32'h0, int'(csr), 0);
    chk("R1 limit reset", lim == 32'h0, int'(lim), 0);
    wr(1'b0, ctl(1, 0, 9));
    chk("R1 field readback", csr[5:0] == 6'b100101, int'(csr[5:0]), 37);
    wr(1'b0, 32'h0);
  endtask

  task automatic t_basic;
    wr(1'b1, {16'd300, 16'd200});
    chk("R5 limit readback", lim == {16'd300, 16'd200}, int'(lim), int'({16'd300, 16'd200}));
    measure(0, "R6 done rises");
    chk_near("R2 count 10ns clock", cnt_of(csr), 255);
    chk("R5 pass in range", csr[7], int'(csr[7]), 1);
    wr(1'b0, ctl(1, 0, 0));
    idle(1);
    chk("R6 done cleared", csr[6:0] == 7'b0000001, int'(csr[7:6]), 0);
    chk("R6 pass cleared", !csr[7], int'(csr[7]), 0);
    chk("R7 count zero after idle", cnt_of(csr) == 0, cnt_of(csr), 0);
  endtask

  task automatic t_second_clk;
    measure(1, "R10 done");
    chk_near("R10 count 8ns clock", cnt_of(csr), 319);
    chk("R5 pass outside (count > high)", !csr[7], int'(csr[7]), 0);
    wr(1'b0, ctl(1, 0, 1));
    idle(1);
  endtask

  task automatic t_sat;
    sat_en = 1'b1;
    measure(2, "R3 done");
    chk("R3 saturated count", cnt_of(csr) == 16383, cnt_of(csr), 16383);
    idle(50);
    chk("R3 count holds while done", cnt_of(csr) == 16383, cnt_of(csr), 16383);
    wr(1'b0, ctl(1, 0, 2));
    idle(1);
    sat_en = 1'b0;
  endtask

  task automatic t_bounds;
    int c;
    wr(1'b1, {16'hFFFF, 16'h0});
    measure(3, "R5 done");
    c = cnt_of(csr);
    chk_near("R2 count 40ns clock", c, 63);
    wr(1'b1, {16'(c), 16'(c)});
    chk("R5 low=high=count passes", csr[7], int'(csr[7]), 1);
    wr(1'b1, {16'(c + 5), 16'(c + 1)});
    chk("R5 low above count fails", !csr[7], int'(csr[7]), 0);
    wr(1'b1, {16'(c - 1), 16'(c - 5)});
    chk("R5 high below count fails", !csr[7], int'(csr[7]), 0);
    wr(1'b0, 32'h0);
    idle(1);
    chk("R9 disable idles", (csr[1:0] == 2'b0) && (csr[7:6] == 2'b0) && (cnt_of(csr) == 0),
        int'(csr), 0);
  endtask

  task automatic t_no_enable;
    wr(1'b0, ctl(0, 1, 0));
    idle(800);
    chk("R4 no done without enable", !csr[6], int'(csr[6]), 0);
    chk("R4 count stays zero", cnt_of(csr) == 0, cnt_of(csr), 0);
    wr(1'b0, 32'h0);
  endtask

  task automatic t_sel_locked;
    wr(1'b0, ctl(1, 0, 3));
    idle(20);
    wr(1'b0, ctl(1, 1, 3));
    idle(50);
    wr(1'b0, ctl(1, 1, 1));
    chk("R8 index unchanged", csr[5:2] == 4'd3, int'(csr[5:2]), 3);
    wait_done("R8 done");
    chk_near("R8 count from original clock", cnt_of(csr), 63);
    wr(1'b0, 32'h0);
    idle(1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_basic;
    t_second_clk;
    t_sat;
    t_bounds;
    t_no_enable;
    t_sel_locked;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule